// File: doc/BRIEF.md
# Dual Interval Timer and Trigger-Go Counter

This block holds two upward-counting interval timers and one event counter with a latched discrete output. An asynchronous timer clock is brought into the system clock domain, and each of its rising edges advances the first timer. A divide-by-ten prescaler driven by the same synchronized edges advances the second timer. A separate asynchronous clock drives the trigger-go counter. When that counter wraps, it pulls an active-low discrete output low. The output stays low until a GO command clears the counter.

Software acts on the block through decoded commands, one per cycle on `cmd_op` while `cmd_valid` is high, and through a combinational read port. Each timer has its own load, start and stop commands. A timer wrap raises a one-cycle interrupt request on that timer's own line.

One active-low freeze input halts every counter, including the prescaler phase. While it is low, commands that would change state are dropped. When it returns high, counting carries on from the held values.

Top module: `interval_timer_unit`

## Requirements
- R1: After reset both timer counts and the trigger-go count read zero, both timers are stopped, `tg_out_n` is high and neither interrupt line is asserted.
- R2: While running, timer A adds one for each rising edge of `tclk_in`, as seen after synchronization into `clk`.
- R3: A prescaler counts every synchronized `tclk_in` rising edge, whether or not timer B runs. It emits a tick on every tenth edge, and a running timer B adds one per tick.
- R4: `cmd_op` 1 loads timer A and 4 loads timer B from `cmd_data`. A load is taken whether the timer runs or not, and it wins over a count tick in the same cycle.
- R5: `cmd_op` 2 starts timer A and 3 stops it; 5 starts timer B and 6 stops it. A stopped timer keeps its value and ignores ticks.
- R6: A timer at all-ones wraps to zero on its next tick and raises a one-cycle pulse: `irq_a` for timer A, `irq_b` for timer B.
- R7: The trigger-go counter adds one for each synchronized rising edge of `tgclk_in`. Its wrap from all-ones to zero drives `tg_out_n` low, and it stays low while the counter keeps counting.
- R8: `cmd_op` 7 (GO) clears the trigger-go count to zero and returns `tg_out_n` high.
- R9: While `freeze_n` is low, no count, prescaler phase or output changes, and every command is ignored. After release, counting resumes from the held values.
- R10: `rd_data` shows timer A for `rd_sel` 0, timer B for 1, the trigger-go count for 2, and zero for 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tclk_in | input | 1 | Asynchronous timer clock |
| tgclk_in | input | 1 | Asynchronous trigger-go clock |
| freeze_n | input | 1 | Active-low global halt and command block |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (see R4, R5, R8) |
| cmd_data | input | TW | Load value |
| rd_sel | input | 2 | Read source select |
| rd_data | output | TW | Selected count |
| irq_a | output | 1 | Timer A wrap pulse |
| irq_b | output | 1 | Timer B wrap pulse |
| tg_out_n | output | 1 | Latched active-low trigger-go discrete |

## Verification
The bench builds the block with 4-bit counters and loads timer A with every value from 0 to 15. Each value gets one tick, so every wrap boundary is covered: a design with the wrong compare would wrap early, or would pulse `irq_a` at the wrong count or for two cycles. Timer B is run across several prescaler phases, some of them while it is stopped. A prescaler that reset on start, or halted while B was stopped, would leave B's count off the arithmetic model.

Ticks, loads and a GO are all sent while frozen. A freeze that failed to block commands or to hold the prescaler phase would show up as moved counts or an early release of `tg_out_n`. The bench also checks that `tg_out_n` stays low while the trigger-go counter keeps counting after its wrap, which catches a design that clears the latch on the next count instead of on GO.

// File: rtl/itu_pkg.sv
package itu_pkg;
  typedef enum logic [2:0] {
    CMD_NONE    = 3'd0,
    CMD_LOAD_A  = 3'd1,
    CMD_START_A = 3'd2,
    CMD_STOP_A  = 3'd3,
    CMD_LOAD_B  = 3'd4,
    CMD_START_B = 3'd5,
    CMD_STOP_B  = 3'd6,
    CMD_GO      = 3'd7
  } itu_cmd_e;

  localparam int NUM_TIMERS = 2;
endpackage

// File: rtl/itu_edge_sync.sv
module itu_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_in};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/itu_prescaler.sv
module itu_prescaler #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick_in,
  output logic tick_out
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] phase_q, phase_d;
  logic          tick_q, tick_d;

  always_comb begin
    phase_d = phase_q;
    tick_d  = 1'b0;
    if (en && tick_in) begin
      if (phase_q == LAST) begin
        phase_d = '0;
        tick_d  = 1'b1;
      end else begin
        phase_d = phase_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      tick_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      tick_q  <= tick_d;
    end
  end

  assign tick_out = tick_q;
endmodule

// File: rtl/itu_timer.sv
module itu_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          load,
  input  logic          start,
  input  logic          stop,
  input  logic [TW-1:0] load_val,
  output logic [TW-1:0] count,
  output logic          running,
  output logic          ovf_pulse
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          ovf_q, ovf_d;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    ovf_d = 1'b0;
    if (en) begin
      if (start) run_d = 1'b1;
      if (stop)  run_d = 1'b0;
      if (load) begin
        cnt_d = load_val;
      end else if (run_q && tick) begin
        cnt_d = cnt_q + 1'b1;
        ovf_d = (cnt_q == '1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      ovf_q <= ovf_d;
    end
  end

  assign count     = cnt_q;
  assign running   = run_q;
  assign ovf_pulse = ovf_q;
endmodule

// File: rtl/itu_tg_counter.sv
module itu_tg_counter #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          go,
  output logic [TW-1:0] count,
  output logic          out_n
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          low_q, low_d;

  always_comb begin
    cnt_d = cnt_q;
    low_d = low_q;
    if (en) begin
      if (go) begin
        cnt_d = '0;
        low_d = 1'b0;
      end else if (tick) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == '1) low_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      low_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      low_q <= low_d;
    end
  end

  assign count = cnt_q;
  assign out_n = ~low_q;
endmodule

// File: rtl/interval_timer_unit.sv
module interval_timer_unit #(
  parameter int TW          = 16,
  parameter int PRESCALE    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tclk_in,
  input  logic          tgclk_in,
  input  logic          freeze_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [TW-1:0] cmd_data,
  input  logic [1:0]    rd_sel,
  output logic [TW-1:0] rd_data,
  output logic          irq_a,
  output logic          irq_b,
  output logic          tg_out_n
);
  import itu_pkg::*;

  localparam int NT = NUM_TIMERS;

  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic tick_t, tick_tg, tick_pre;

  itu_edge_sync #(.STAGES(SYNC_STAGES)) u_tsync (
    .clk(clk), .rst_n(rst_n_i), .async_in(tclk_in), .rise_o(tick_t)
  );

  itu_edge_sync #(.STAGES(SYNC_STAGES)) u_tgsync (
    .clk(clk), .rst_n(rst_n_i), .async_in(tgclk_in), .rise_o(tick_tg)
  );

  itu_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n_i), .en(freeze_n), .tick_in(tick_t), .tick_out(tick_pre)
  );

  logic          acc;
  logic [NT-1:0] ld, st, sp, tk, run, ovf;
  logic          go;
  logic [TW-1:0] cnt [NT];
  logic [TW-1:0] cnt_tg;

  always_comb begin
    acc   = cmd_valid & freeze_n;
    ld[0] = acc && (cmd_op == CMD_LOAD_A);
    st[0] = acc && (cmd_op == CMD_START_A);
    sp[0] = acc && (cmd_op == CMD_STOP_A);
    ld[1] = acc && (cmd_op == CMD_LOAD_B);
    st[1] = acc && (cmd_op == CMD_START_B);
    sp[1] = acc && (cmd_op == CMD_STOP_B);
    go    = acc && (cmd_op == CMD_GO);
    tk[0] = tick_t;
    tk[1] = tick_pre;
  end

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    itu_timer #(.TW(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n_i), .en(freeze_n), .tick(tk[g]),
      .load(ld[g]), .start(st[g]), .stop(sp[g]), .load_val(cmd_data),
      .count(cnt[g]), .running(run[g]), .ovf_pulse(ovf[g])
    );
  end

  itu_tg_counter #(.TW(TW)) u_tg (
    .clk(clk), .rst_n(rst_n_i), .en(freeze_n), .tick(tick_tg), .go(go),
    .count(cnt_tg), .out_n(tg_out_n)
  );

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = cnt[0];
      2'd1:    rd_data = cnt[1];
      2'd2:    rd_data = cnt_tg;
      default: rd_data = '0;
    endcase
  end

  assign irq_a = ovf[0];
  assign irq_b = ovf[1];
endmodule

// File: rtl/itu_checker.sv
module itu_checker #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          freeze_n,
  input logic          cmd_valid,
  input logic [2:0]    cmd_op,
  input logic          irq_a,
  input logic          irq_b,
  input logic          tg_out_n,
  input logic          run_a,
  input logic [TW-1:0] cnt_a,
  input logic [TW-1:0] cnt_b,
  input logic [TW-1:0] cnt_tg
);
  // R6
  irq_a_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a |=> !irq_a);

  // R6
  irq_b_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_b |=> !irq_b);

  // R6
  irq_a_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a |-> (cnt_a == '0));

  // R5
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_a && !(cmd_valid && cmd_op == 3'd1)) |=> $stable(cnt_a));

  // R9
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze_n |=> ($stable(cnt_a) && $stable(cnt_b) && $stable(cnt_tg) && $stable(tg_out_n)));

  // R7
  tg_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tg_out_n && !(cmd_valid && freeze_n && cmd_op == 3'd7)) |=> !tg_out_n);
endmodule

bind interval_timer_unit itu_checker #(.TW(TW)) u_itu_chk (
  .clk(clk), .rst_n(rst_n_i), .freeze_n(freeze_n), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .irq_a(irq_a), .irq_b(irq_b), .tg_out_n(tg_out_n),
  .run_a(run[0]), .cnt_a(cnt[0]), .cnt_b(cnt[1]), .cnt_tg(cnt_tg)
);

// File: tb/interval_timer_unit_bench.sv
`timescale 1ns/1ps
module interval_timer_unit_bench;
  localparam int TW  = 4;
  localparam int PS  = 10;
  localparam int MOD = 1 << TW;

  logic          clk = 1'b0;
  logic          rst_n, tclk_in, tgclk_in, freeze_n, cmd_valid;
  logic [2:0]    cmd_op;
  logic [TW-1:0] cmd_data;
  logic [1:0]    rd_sel;
  logic [TW-1:0] rd_data;
  logic          irq_a, irq_b, tg_out_n;

  always #4 clk = ~clk;

  interval_timer_unit #(.TW(TW), .PRESCALE(PS)) u_interval_timer_unit (
    .clk(clk), .rst_n(rst_n), .tclk_in(tclk_in), .tgclk_in(tgclk_in),
    .freeze_n(freeze_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq_a(irq_a), .irq_b(irq_b), .tg_out_n(tg_out_n)
  );

  int n_chk = 0, n_fail = 0;
  int m_a = 0, m_b = 0, m_tg = 0, m_pre = 0;
  bit run_a = 0, run_b = 0, frz = 0, m_tglow = 0;
  int irqa_seen = 0, irqb_seen = 0, irqa_exp = 0, irqb_exp = 0;
  int irq_run = 0, irq_run_max = 0;

  always @(negedge clk) begin
    if (irq_a) irqa_seen++;
    if (irq_b) irqb_seen++;
    if (irq_a || irq_b) begin
      irq_run++;
      if (irq_run > irq_run_max) irq_run_max = irq_run;
    end else irq_run = 0;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic rd(input int sel, output int v);
    rd_sel = 2'(sel);
    #1 v = int'(rd_data);
  endtask

  task automatic cmd(input int op, input int data = 0);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_data = TW'(data);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
    if (!frz) begin
      case (op)
        1: m_a = data % MOD;
        2: run_a = 1;
        3: run_a = 0;
        4: m_b = data % MOD;
        5: run_b = 1;
        6: run_b = 0;
        7: begin m_tg = 0; m_tglow = 0; end
        default: ;
      endcase
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_t(input int n);
    for (int i = 0; i < n; i++) begin
      tclk_in = 1'b1; repeat (4) @(negedge clk);
      tclk_in = 1'b0; repeat (4) @(negedge clk);
      if (!frz) begin
        if (run_a) begin
          if (m_a == MOD - 1) irqa_exp++;
          m_a = (m_a + 1) % MOD;
        end
        m_pre++;
        if (m_pre == PS) begin
          m_pre = 0;
          if (run_b) begin
            if (m_b == MOD - 1) irqb_exp++;
            m_b = (m_b + 1) % MOD;
          end
        end
      end
    end
  endtask

  task automatic pulse_tg(input int n);
    for (int i = 0; i < n; i++) begin
      tgclk_in = 1'b1; repeat (4) @(negedge clk);
      tgclk_in = 1'b0; repeat (4) @(negedge clk);
      if (!frz) begin
        if (m_tg == MOD - 1) m_tglow = 1;
        m_tg = (m_tg + 1) % MOD;
      end
    end
  endtask

  task automatic check_all(string req);
    int v;
    rd(0, v); check({req, " timer A"}, v, m_a);
    rd(1, v); check({req, " timer B"}, v, m_b);
    rd(2, v); check({req, " trigger-go count"}, v, m_tg);
    check({req, " tg_out_n"}, int'(tg_out_n), m_tglow ? 0 : 1);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    int v;
    rst_n = 1'b0; tclk_in = 1'b0; tgclk_in = 1'b0; freeze_n = 1'b1;
    cmd_valid = 1'b0; cmd_op = 3'd0; cmd_data = '0; rd_sel = 2'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_all("R1");
    check("R1 irq_a", int'(irq_a), 0);
    check("R1 irq_b", int'(irq_b), 0);

    // R5 stopped timers ignore ticks
    pulse_t(3);
    check_all("R5");

    // R2 running timer A counts edges
    cmd(2);
    pulse_t(5);
    check_all("R2");

    // R4 R6 exhaustive load sweep with one tick each
    for (int val = 0; val < MOD; val++) begin
      cmd(1, val);
      pulse_t(1);
      rd(0, v); check("R4 R6 load+tick", v, (val + 1) % MOD);
      check("R6 irq_a count", irqa_seen, irqa_exp);
    end

    // R5 stop A
    cmd(3);
    pulse_t(2);
    check_all("R5 stop");

    // R3 timer B across prescaler phases
    cmd(5);
    pulse_t(25);
    check_all("R3");
    cmd(6);
    pulse_t(7);
    check_all("R3 stopped B, prescaler runs");
    cmd(5);
    cmd(4, MOD - 2);
    pulse_t(30);
    check_all("R3 R6 B wrap");
    check("R6 irq_b count", irqb_seen, irqb_exp);

    // R7 trigger-go counting and latch
    pulse_tg(5);
    check_all("R7");
    pulse_tg(MOD - 5);
    check_all("R7 wrap latch");
    pulse_tg(3);
    check_all("R7 latch holds");
    // R8 GO
    cmd(7);
    check_all("R8");

    // R9 freeze: set up latched output, then freeze
    pulse_tg(MOD);
    cmd(2);
    freeze_n = 1'b0; frz = 1;
    @(negedge clk);
    cmd(1, 7);
    cmd(6);
    cmd(7);
    pulse_t(13);
    pulse_tg(4);
    check_all("R9 frozen");
    freeze_n = 1'b1; frz = 0;
    @(negedge clk);
    pulse_t(12);
    pulse_tg(2);
    check_all("R9 resume");
    cmd(7);
    check_all("R9 GO after release");

    check("R6 irq pulse width", irq_run_max, 1);
    rd(3, v); check("R10 unused select", v, 0);

    finish_sim();
  end
endmodule